// File: doc/BRIEF.md
# Two-Byte Handshake Output Sequencer

This block hands a 14-bit conversion result to a UART-style transmitter as two bytes, high byte first. The receiver paces the transfer through its ready line. A load strobe marks the byte the receiver must capture, and two active-low byte enables show which half is on the bus. The data bus carries an output-enable flag and reads zero whenever it is not driven.

The block runs on a clock at twice the rate of its internal clock. Edges alternate between the rising and falling phases of the internal clock, and the first edge after reset is a rising phase. Handshake mode starts in one of two ways. With the mode input held high, it starts automatically each time a new result is stored. It also starts on a low-to-high transition of the mode input. While handshake mode is active, the result latch is frozen and the mode input is ignored. A result that arrives during a handshake is dropped.

Top module: `hs_byte_sequencer`

## Requirements
- R1: While reset is asserted, the load strobe and both byte enables are high, the data-output flag is low, the bus reads 0 and the busy flag is low.
- R2: With the mode input high and idle, a new-data strobe stores the result and sets busy on that same edge; with the mode input low it only stores the result and busy stays low.
- R3: When idle, a low-to-high transition of the mode input sets busy on the edge that sees it. If a new-data strobe falls on that same edge, the bytes sent carry the new result.
- R4: While busy, the mode input is ignored: a transition during a handshake starts no further handshake after it ends.
- R5: While busy, the result latch is frozen; a result strobed during a handshake is lost and a later handshake resends the earlier result.
- R6: The ready input is sampled only on falling-phase edges. A byte phase starts (load low) on the rising-phase edge right after a falling-phase edge that saw ready high while waiting.
- R7: The load strobe stays low for exactly two edges (one internal clock period), and goes low on the same edge as its byte enable and the data-output flag.
- R8: With ready held high, each byte is driven for three edges and its enable is low for four edges.
- R9: If ready is low after the load strobe rises, enable and data hold; the data is released on the first falling-phase edge that sees ready high, and the enable rises on the next edge.
- R10: The low-byte phase (load and low enable low, low byte driven) starts on the edge where the high enable rises, and follows the timing of R7 to R9.
- R11: On the edge where the low enable rises, handshake mode ends: busy drops and load and both enables are high.
- R12: The result word is {overrange, polarity, d12..d1} (bit 13 down to 0). The high byte is {2'b00, overrange, polarity, d12..d9} and the low byte is d8..d1.
- R13: The data bus reads 0 whenever the data-output flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock; edges alternate rising and falling phases |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode level / trigger edge |
| send_i | input | 1 | Receiver ready |
| new_data_i | input | 1 | New result strobe |
| result_i | input | 14 | Result word {overrange, polarity, d12..d1} |
| load_no | output | 1 | Active-low load strobe; receiver captures on its rising edge |
| hi_en_no | output | 1 | Active-low high-byte enable |
| lo_en_no | output | 1 | Active-low low-byte enable |
| data_o | output | 8 | Byte bus, zero when not driven |
| data_oe_o | output | 1 | Bus driven flag |
| busy_o | output | 1 | Handshake active / latch inhibit |

## Verification
Two events can land on the same edge: a rising mode edge and a new-data strobe. The bench raises both inputs before the same edge while the latch holds a different older value. Entry is judged correct only if busy rises on that edge and both captured bytes match the new result. A second case puts a mode transition and a new-data strobe inside a running handshake. The block must then stay idle afterwards and later resend the old result.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT,
    S_ARM,
    S_HI_LD,
    S_HI_HOLD,
    S_HI_REL,
    S_LO_LD,
    S_LO_HOLD,
    S_LO_REL
  } hs_state_e;
endpackage

// File: rtl/hs_phase_gen.sv
module hs_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rise_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  // current edge is a rising phase when ph_q is low
  assign rise_o = ~ph_q;
endmodule

// File: rtl/hs_entry_ctrl.sv
module hs_entry_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic new_data_i,
  input  logic idle_i,
  output logic enter_o,
  output logic store_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end

  // store and entry share the edge: bytes read the latch only after it
  assign store_o = idle_i & new_data_i;
  assign enter_o = idle_i & mode_i & (~mode_q | new_data_i);
endmodule

// File: rtl/hs_result_latch.sv
module hs_result_latch #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8,
  localparam int RES_W = DATA_W + 2,
  localparam int HI_W  = DATA_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic              idle_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [BYTE_W-1:0] hi_byte_o,
  output logic [BYTE_W-1:0] lo_byte_o
);
  logic [RES_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (store_i) lat_q <= result_i;
  end

  always_comb begin
    hi_byte_o = '0;
    hi_byte_o[HI_W-1:0] = lat_q[DATA_W-1:BYTE_W];
    hi_byte_o[HI_W]     = lat_q[DATA_W];
    hi_byte_o[HI_W+1]   = lat_q[DATA_W+1];
    lo_byte_o = lat_q[BYTE_W-1:0];
  end

  p_latch_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(lat_q));
endmodule

// File: rtl/hs_byte_seq.sv
module hs_byte_seq
  import hs_seq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              enter_i,
  input  logic              send_i,
  input  logic [BYTE_W-1:0] hi_byte_i,
  input  logic [BYTE_W-1:0] lo_byte_i,
  output logic              idle_o,
  output logic              load_no,
  output logic              hi_en_no,
  output logic              lo_en_no,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  hs_state_e st_q, st_d;
  logic      fall_send;

  assign fall_send = ~rise_i & send_i;
  assign idle_o    = (st_q == S_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (enter_i)   st_d = S_WAIT;
      S_WAIT:    if (fall_send) st_d = S_ARM;
      S_ARM:     if (rise_i)    st_d = S_HI_LD;
      S_HI_LD:   if (rise_i)    st_d = S_HI_HOLD;
      S_HI_HOLD: if (fall_send) st_d = S_HI_REL;
      S_HI_REL:  if (rise_i)    st_d = S_LO_LD;
      S_LO_LD:   if (rise_i)    st_d = S_LO_HOLD;
      S_LO_HOLD: if (fall_send) st_d = S_LO_REL;
      S_LO_REL:  if (rise_i)    st_d = S_IDLE;
      default:                  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      load_no   <= 1'b1;
      hi_en_no  <= 1'b1;
      lo_en_no  <= 1'b1;
      data_o    <= '0;
      data_oe_o <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      load_no   <= ~(st_d inside {S_HI_LD, S_LO_LD});
      hi_en_no  <= ~(st_d inside {S_HI_LD, S_HI_HOLD, S_HI_REL});
      lo_en_no  <= ~(st_d inside {S_LO_LD, S_LO_HOLD, S_LO_REL});
      data_oe_o <= st_d inside {S_HI_LD, S_HI_HOLD, S_LO_LD, S_LO_HOLD};
      busy_o    <= (st_d != S_IDLE);
      if (st_d inside {S_HI_LD, S_HI_HOLD})      data_o <= hi_byte_i;
      else if (st_d inside {S_LO_LD, S_LO_HOLD}) data_o <= lo_byte_i;
      else                                       data_o <= '0;
    end
  end

  p_enter_only_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |-> st_q == S_IDLE);
  p_load_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_no) |-> !rise_i);
  p_load_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_no) |=> !load_no);
  p_load_second_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_no && !$past(load_no)) |=> load_no);
  p_lo_follows_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_en_no) |-> !lo_en_no);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (load_no && hi_en_no && lo_en_no));
  p_bus_owned_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (hi_en_no != lo_en_no));
endmodule

// File: rtl/hs_byte_sequencer.sv
module hs_byte_sequencer #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8,
  localparam int RES_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              send_i,
  input  logic              new_data_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              load_no,
  output logic              hi_en_no,
  output logic              lo_en_no,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  logic              rise, enter, store, idle;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  hs_phase_gen u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_o (rise)
  );

  hs_entry_ctrl u_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .new_data_i (new_data_i),
    .idle_i     (idle),
    .enter_o    (enter),
    .store_o    (store)
  );

  hs_result_latch #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .store_i   (store),
    .idle_i    (idle),
    .result_i  (result_i),
    .hi_byte_o (hi_byte),
    .lo_byte_o (lo_byte)
  );

  hs_byte_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .enter_i   (enter),
    .send_i    (send_i),
    .hi_byte_i (hi_byte),
    .lo_byte_i (lo_byte),
    .idle_o    (idle),
    .load_no   (load_no),
    .hi_en_no  (hi_en_no),
    .lo_en_no  (lo_en_no),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .busy_o    (busy_o)
  );
endmodule

// File: tb/hs_byte_sequencer_test.sv
`timescale 1ns/1ps
module hs_byte_sequencer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        send_i = 1'b1;
  logic        new_data_i = 1'b0;
  logic [13:0] result_i = '0;
  logic        load_no, hi_en_no, lo_en_no, data_oe_o, busy_o;
  logic [7:0]  data_o;

  int checks = 0;
  int fails = 0;
  int n = 0;

  // monitor state
  logic       p_load = 1, p_hen = 1, p_len = 1, p_oe = 0, p_busy = 0;
  logic [7:0] p_data = 0;
  logic [7:0] cap_b [4];
  bit         cap_h [4];
  int         ld_w [4];
  int         oe_w [4];
  int         ncap, hw_h, hw_l;
  int         t_load_fall, t_first_fall, t_oe_rise, t_hb_fall, t_hb_rise;
  int         t_lb_fall, t_lb_rise, t_busy_rise, t_busy_fall, zero_viol;
  bit         ev_load_rise;

  always #2 clk_i = ~clk_i;

  hs_byte_sequencer uut (
    .clk_i, .rst_ni, .mode_i, .send_i, .new_data_i, .result_i,
    .load_no, .hi_en_no, .lo_en_no, .data_o, .data_oe_o, .busy_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; t_first_fall = -1; ev_load_rise = 0;
  endtask

  task automatic sample();
    n++;
    ev_load_rise = 0;
    if (!data_oe_o && data_o != 0) zero_viol++;
    if (p_load && !load_no) begin
      t_load_fall = n;
      if (ncap == 0) t_first_fall = n;
    end
    if (!p_load && load_no && ncap < 4) begin
      cap_b[ncap] = p_data; cap_h[ncap] = !p_hen;
      ld_w[ncap] = n - t_load_fall; ncap++; ev_load_rise = 1;
    end
    if (!p_oe && data_oe_o) t_oe_rise = n;
    if (p_oe && !data_oe_o && ncap > 0) oe_w[ncap-1] = n - t_oe_rise;
    if (p_hen && !hi_en_no) t_hb_fall = n;
    if (!p_hen && hi_en_no) begin t_hb_rise = n; hw_h = n - t_hb_fall; end
    if (p_len && !lo_en_no) t_lb_fall = n;
    if (!p_len && lo_en_no) begin t_lb_rise = n; hw_l = n - t_lb_fall; end
    if (!p_busy && busy_o) t_busy_rise = n;
    if (p_busy && !busy_o) t_busy_fall = n;
    p_load = load_no; p_hen = hi_en_no; p_len = lo_en_no;
    p_oe = data_oe_o; p_busy = busy_o; p_data = data_o;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    sample();
  endtask

  function automatic logic [7:0] hi_of(input logic [13:0] r);
    return {2'b00, r[13], r[12], r[11:8]};
  endfunction

  // R8/R9: drive width for a stall of s edges after the load rises
  function automatic int exp_oe(input int s);
    return (s % 2 == 0) ? s + 3 : s + 4;
  endfunction

  task automatic pump(input int pre, input int sh, input int sl,
                      input bit poke, input logic [13:0] pv);
    int st = 0;
    int pre_left = pre;
    for (int k = 0; k < 400; k++) begin
      if (pre_left > 0) begin send_i = 0; pre_left--; end
      else if (st > 0) begin send_i = 0; st--; end
      else send_i = 1;
      if (poke) begin
        mode_i = (k == 2) ? 1'b0 : 1'b1;
        new_data_i = (k == 4);
        if (k == 4) result_i = pv;
      end
      tick();
      if (ev_load_rise) st = (ncap == 1) ? sh : sl;
      if (!busy_o) break;
    end
    send_i = 1; new_data_i = 0;
  endtask

  task automatic check_xfer(input logic [13:0] r, input int pre,
                            input int sh, input int sl);
    int f;
    chk(ncap == 2, "R12", "bytes captured", ncap, 2);
    chk(cap_h[0] && cap_b[0] == hi_of(r), "R12", "high byte", cap_b[0], hi_of(r));
    chk(!cap_h[1] && cap_b[1] == r[7:0], "R10", "low byte", cap_b[1], r[7:0]);
    chk(ld_w[0] == 2 && ld_w[1] == 2, "R7", "load width", ld_w[0]*10+ld_w[1], 22);
    chk(oe_w[0] == exp_oe(sh), (sh == 0) ? "R8" : "R9", "high drive", oe_w[0], exp_oe(sh));
    chk(hw_h == exp_oe(sh) + 1, (sh == 0) ? "R8" : "R9", "high enable", hw_h, exp_oe(sh)+1);
    chk(oe_w[1] == exp_oe(sl), "R10", "low drive", oe_w[1], exp_oe(sl));
    chk(hw_l == exp_oe(sl) + 1, "R10", "low enable", hw_l, exp_oe(sl)+1);
    chk(t_lb_fall == t_hb_rise, "R10", "low phase start", t_lb_fall, t_hb_rise);
    chk(t_busy_fall == t_lb_rise && load_no && hi_en_no && lo_en_no, "R11",
        "end of handshake", t_busy_fall, t_lb_rise);
    // R6: first falling-phase edge (even n) after the wait, load one edge later
    f = t_busy_rise + pre + 1;
    if (f % 2 == 1) f++;
    chk(t_first_fall == f + 1, "R6", "high phase start", t_first_fall, f + 1);
  endtask

  task automatic t_reset();
    chk(load_no && hi_en_no && lo_en_no, "R1", "strobes high", {load_no,hi_en_no,lo_en_no}, 7);
    chk(!data_oe_o && data_o == 0 && !busy_o, "R1", "bus and busy", {data_oe_o,busy_o}, 0);
  endtask

  task automatic t_store_then_edge(input logic [13:0] r);
    clear_mon();
    mode_i = 0; new_data_i = 1; result_i = r;
    tick();
    new_data_i = 0; result_i = '0;
    tick(); tick(); tick();
    chk(!busy_o, "R2", "no entry with mode low", busy_o, 0);
    mode_i = 1;
    tick();
    chk(busy_o, "R3", "mode edge entry", busy_o, 1);
    mode_i = 0;
    pump(0, 0, 0, 0, '0);
    check_xfer(r, 0, 0, 0);
  endtask

  task automatic t_stall(input logic [13:0] r);
    clear_mon();
    mode_i = 1; send_i = 0;
    tick();
    chk(busy_o, "R3", "mode edge entry (stall run)", busy_o, 1);
    mode_i = 0;
    pump(5, 4, 3, 0, '0);
    check_xfer(r, 5, 4, 3);
  endtask

  task automatic t_collision(input logic [13:0] r);
    clear_mon();
    mode_i = 1; new_data_i = 1; result_i = r;
    tick();
    new_data_i = 0;
    chk(busy_o, "R3", "entry with same-edge store", busy_o, 1);
    pump(0, 0, 0, 0, '0);
    check_xfer(r, 0, 0, 0);
  endtask

  task automatic t_auto_poke(input logic [13:0] r, input logic [13:0] lost);
    clear_mon();
    mode_i = 1; new_data_i = 1; result_i = r;
    tick();
    new_data_i = 0;
    chk(busy_o, "R2", "auto entry on store", busy_o, 1);
    pump(0, 1, 2, 1, lost);
    check_xfer(r, 0, 1, 2);
    for (int i = 0; i < 6; i++) tick();
    chk(!busy_o, "R4", "mode edge during handshake ignored", busy_o, 0);
    mode_i = 0;
    tick();
    clear_mon();
    mode_i = 1;
    tick();
    chk(busy_o, "R3", "re-entry on mode edge", busy_o, 1);
    pump(0, 0, 0, 0, '0);
    chk(ncap == 2 && cap_b[0] == hi_of(r) && cap_b[1] == r[7:0], "R5",
        "result during handshake lost", {cap_b[0], cap_b[1]}, {hi_of(r), r[7:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    zero_viol = 0;
    clear_mon();
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1;
    n = 0;
    t_store_then_edge(14'h1A5C);
    t_stall(14'h1A5C);
    t_collision(14'h2F31);
    t_auto_poke(14'h3C96, 14'h0123);
    chk(zero_viol == 0, "R13", "bus zero when undriven", zero_viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule